// File: doc/BRIEF.md
# Packed SIMD Integer Multiply-Accumulate

This block is a lane-partitioned integer multiply-accumulate datapath for packed 128-bit vectors. It takes two source vectors and an accumulator vector and splits them into independent lanes of 8, 16 or 32 bits. For each lane it multiplies the two source elements and then either adds the product to the accumulator lane or subtracts it. Carries never pass from one lane into the next. The packed result is returned after a fixed two-stage pipeline.

There are three operating shapes. The full mode processes all 128 bits. The half mode processes only the low 64 bits and returns the upper accumulator half untouched. The widening mode multiplies elements taken from the low 64 bits of the sources into accumulator lanes of twice the element width, which fill all 128 bits. In widening mode a signed flag chooses sign or zero extension of the source elements. In the other modes that flag does not matter.

The input side uses a valid/ready handshake. The output side presents a valid flag and accepts a ready flag. When the output is held, the whole pipeline stalls.

Top module: `simd_mac`

## Requirements
- R1: With `size_sel` 00, 01 or 10 (8-, 16- or 32-bit elements), full mode and no subtraction, every lane i of `result` equals (acc_in[i] + src_a[i] * src_b[i]) modulo 2^esize. Lane i occupies bits [i*esize +: esize].
- R2: With `sub_mode` = 1 outside widening mode, every lane equals (acc_in[i] - src_a[i] * src_b[i]) modulo 2^esize.
- R3: Lanes are independent. A lane whose sum or product overflows, for example with all-ones operands, changes no bit of a neighbouring lane.
- R4: With `half_mode` = 1 and `wide_mode` = 0, the low 64 bits follow R1/R2 and `result[127:64]` equals `acc_in[127:64]`.
- R5: With `wide_mode` = 1, element i of width esize is taken from bits [i*esize +: esize] of the low 64 bits of each source. Lane i of the result, at bits [i*2*esize +: 2*esize], equals acc_in lane ± the product of both elements, extended by sign when `signed_mode` = 1 and by zeros otherwise, taken modulo 2^(2*esize). `half_mode` is ignored in this mode.
- R6: Outside widening mode, `signed_mode` has no effect on `result`.
- R7: `size_sel` = 11 is reserved. It sets `illegal_op` to 1 and makes `result` equal to `acc_in`. Legal sizes give `illegal_op` = 0.
- R8: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1. With `out_ready` held at 1, `out_valid` and its result appear after the second rising edge, and a new input may be accepted on every cycle.
- R9: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_valid`, `result` and `illegal_op` hold their values.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and mode are valid |
| in_ready | output | 1 | Pipeline can take an operand set |
| size_sel | input | 2 | Element width: 00 = 8, 01 = 16, 10 = 32, 11 = reserved |
| half_mode | input | 1 | Process only the low 64 bits |
| wide_mode | input | 1 | Widening accumulate into 2*esize lanes |
| sub_mode | input | 1 | Subtract the product instead of adding it |
| signed_mode | input | 1 | Sign-extend elements in widening mode |
| src_a | input | 128 | First packed source |
| src_b | input | 128 | Second packed source |
| acc_in | input | 128 | Packed accumulator |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 128 | Packed accumulated result |
| illegal_op | output | 1 | Reserved size code was used |

## Verification
The hardest case to reach from the ports is signed widening subtraction in lanes whose element's top bit is set, right next to lanes that overflow. A sign-extension or carry fault appears there only in the upper half of a wide lane or in a neighbouring lane. The bench sweeps every combination of size, shape, operation and signedness, each with an all-ones pattern, a pattern with only element top bits set, and random operands. The output-stall case needs the consumer to withhold ready while a result is pending. The bench drives that scenario on purpose and watches the held output and the refused input.

// File: rtl/simd_mac.sv
module simd_mac #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    size_sel,
  input  logic          half_mode,
  input  logic          wide_mode,
  input  logic          sub_mode,
  input  logic          signed_mode,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] acc_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [VW-1:0] result,
  output logic          illegal_op
);
  localparam int HW = VW / 2;

  logic          s1_v, s1_half, s1_wide, s1_sub, s1_sgn;
  logic [1:0]    s1_size;
  logic [VW-1:0] s1_a, s1_b, s1_acc;
  logic [VW-1:0] nar_sel, wid_sel, nxt;
  logic          advance;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  for (genvar k = 0; k < 3; k++) begin : g_sz
    localparam int E  = 8 << k;
    localparam int NN = VW / E;
    localparam int NW = HW / E;
    logic [VW-1:0] narrow, wide;

    for (genvar i = 0; i < NN; i++) begin : g_n
      logic [E-1:0] x, y, c, p;
      assign x = s1_a[i*E +: E];
      assign y = s1_b[i*E +: E];
      assign c = s1_acc[i*E +: E];
      assign p = x * y;
      assign narrow[i*E +: E] = s1_sub ? c - p : c + p;
    end

    for (genvar i = 0; i < NW; i++) begin : g_w
      logic [2*E-1:0] x, y, c, p;
      assign x = {{E{s1_sgn & s1_a[i*E+E-1]}}, s1_a[i*E +: E]};
      assign y = {{E{s1_sgn & s1_b[i*E+E-1]}}, s1_b[i*E +: E]};
      assign c = s1_acc[i*2*E +: 2*E];
      assign p = x * y;
      assign wide[i*2*E +: 2*E] = s1_sub ? c - p : c + p;
    end
  end

  always_comb begin
    case (s1_size)
      2'd0:    begin nar_sel = g_sz[0].narrow; wid_sel = g_sz[0].wide; end
      2'd1:    begin nar_sel = g_sz[1].narrow; wid_sel = g_sz[1].wide; end
      2'd2:    begin nar_sel = g_sz[2].narrow; wid_sel = g_sz[2].wide; end
      default: begin nar_sel = s1_acc;         wid_sel = s1_acc;         end
    endcase
  end

  assign nxt = (s1_size == 2'd3) ? s1_acc :
               s1_wide           ? wid_sel :
               s1_half           ? {s1_acc[VW-1:HW], nar_sel[HW-1:0]} :
                                   nar_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v       <= 1'b0;
      s1_size    <= 2'd0;
      s1_half    <= 1'b0;
      s1_wide    <= 1'b0;
      s1_sub     <= 1'b0;
      s1_sgn     <= 1'b0;
      s1_a       <= '0;
      s1_b       <= '0;
      s1_acc     <= '0;
      out_valid  <= 1'b0;
      result     <= '0;
      illegal_op <= 1'b0;
    end else if (advance) begin
      s1_v       <= in_valid;
      s1_size    <= size_sel;
      s1_half    <= half_mode;
      s1_wide    <= wide_mode;
      s1_sub     <= sub_mode;
      s1_sgn     <= signed_mode;
      s1_a       <= src_a;
      s1_b       <= src_b;
      s1_acc     <= acc_in;
      out_valid  <= s1_v;
      result     <= nxt;
      illegal_op <= (s1_size == 2'd3);
    end
  end
endmodule

module simd_mac_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic          in_ready,
  input logic [VW-1:0] result,
  input logic          illegal_op,
  input logic          s1_v,
  input logic [1:0]    s1_size,
  input logic          s1_half,
  input logic          s1_wide,
  input logic [VW-1:0] s1_acc,
  input logic          advance
);
  localparam int HW = VW / 2;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result) && $stable(illegal_op)));

  // R9
  stall_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && advance && s1_size == 2'd3) |=> (illegal_op && result == $past(s1_acc)));

  // R4
  half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && advance && s1_size != 2'd3 && !s1_wide && s1_half) |=>
      (result[VW-1:HW] == $past(s1_acc[VW-1:HW])));

  // R8
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(s1_v));
endmodule

bind simd_mac simd_mac_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .in_ready(in_ready), .result(result), .illegal_op(illegal_op), .s1_v(s1_v),
  .s1_size(s1_size), .s1_half(s1_half), .s1_wide(s1_wide), .s1_acc(s1_acc),
  .advance(advance)
);

// File: tb/test_simd_mac.sv
`timescale 1ns/1ps
module test_simd_mac;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_ready;
  logic [1:0]   size_sel = 2'd0;
  logic         half_mode = 1'b0, wide_mode = 1'b0, sub_mode = 1'b0, signed_mode = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic         out_valid, out_ready = 1'b1;
  logic [127:0] result;
  logic         illegal_op;

  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  simd_mac i_simd_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .size_sel(size_sel), .half_mode(half_mode), .wide_mode(wide_mode),
    .sub_mode(sub_mode), .signed_mode(signed_mode), .src_a(src_a),
    .src_b(src_b), .acc_in(acc_in), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .illegal_op(illegal_op)
  );

  function automatic logic [128:0] model(logic [127:0] a, b, c, logic [1:0] sz,
                                         logic hf, wd, sb, sg);
    logic [127:0] r;
    longint unsigned m, m2, x, y, z, p;
    int e;
    if (sz == 2'd3) return {1'b1, c};
    e = 8 << sz;
    m = (64'd1 << e) - 64'd1;
    r = c;
    if (!wd) begin
      for (int i = 0; i < (hf ? 64 : 128) / e; i++) begin
        x = 64'(a >> (i*e)) & m;
        y = 64'(b >> (i*e)) & m;
        z = 64'(c >> (i*e)) & m;
        p = x * y;
        z = (sb ? z - p : z + p) & m;
        r = (r & ~(128'(m) << (i*e))) | (128'(z) << (i*e));
      end
    end else begin
      m2 = (e == 32) ? ~64'd0 : (64'd1 << (2*e)) - 64'd1;
      for (int i = 0; i < 64 / e; i++) begin
        x = 64'(a >> (i*e)) & m;
        y = 64'(b >> (i*e)) & m;
        if (sg && x[e-1]) x = x | ~m;
        if (sg && y[e-1]) y = y | ~m;
        z = 64'(c >> (i*2*e)) & m2;
        p = x * y;
        z = (sb ? z - p : z + p) & m2;
        r = (r & ~(128'(m2) << (i*2*e))) | (128'(z) << (i*2*e));
      end
    end
    return {1'b0, r};
  endfunction

  task automatic check(string tg, logic [128:0] got, logic [128:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  task automatic drive(logic [127:0] a, b, c, logic [1:0] sz, logic hf, wd, sb, sg);
    src_a = a; src_b = b; acc_in = c; size_sel = sz;
    half_mode = hf; wide_mode = wd; sub_mode = sb; signed_mode = sg;
  endtask

  task automatic run_one(logic [127:0] a, b, c, logic [1:0] sz, logic hf, wd, sb, sg,
                         output logic [128:0] got);
    @(negedge clk);
    drive(a, b, c, sz, hf, wd, sb, sg);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 early", 129'(out_valid), 129'(0));
    @(negedge clk);
    check("R8 latency", 129'(out_valid), 129'(1));
    got = {illegal_op, result};
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [128:0] got, got2;
    logic [127:0] a, b, c;
    logic [128:0] exp_q [4];
    logic [127:0] qa [4], qb [4], qc [4];
    string tg;

    repeat (3) @(negedge clk);
    check("R10 out_valid", 129'(out_valid), 129'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 out_valid", 129'(out_valid), 129'(0));
    check("R10 in_ready", 129'(in_ready), 129'(1));

    for (int sz = 0; sz < 4; sz++)
      for (int mode = 0; mode < 16; mode++)
        for (int pat = 0; pat < 12; pat++) begin
          logic hf, wd, sb, sg;
          {hf, wd, sb, sg} = 4'(mode);
          if (pat == 0) begin a = '1; b = '1; c = '1; end
          else if (pat == 1) begin a = {16{8'h80}}; b = {8{16'h8001}}; c = {4{32'h7fff_ff80}}; end
          else begin a = rnd128(); b = rnd128(); c = rnd128(); end
          if (sz == 3) tg = "R7";
          else if (wd) tg = "R5";
          else if (pat == 0) tg = "R3";
          else if (hf) tg = "R4";
          else if (sb) tg = "R2";
          else tg = "R1";
          run_one(a, b, c, 2'(sz), hf, wd, sb, sg, got);
          check(tg, got, model(a, b, c, 2'(sz), hf, wd, sb, sg));
        end

    // R6: signedness ignored outside widening mode
    for (int sz = 0; sz < 3; sz++)
      for (int k = 0; k < 4; k++) begin
        a = rnd128(); b = rnd128(); c = rnd128();
        run_one(a, b, c, 2'(sz), k[0], 1'b0, k[1], 1'b0, got);
        run_one(a, b, c, 2'(sz), k[0], 1'b0, k[1], 1'b1, got2);
        check("R6", got2, got);
      end

    // R8: back-to-back stream, one result per cycle
    for (int k = 0; k < 4; k++) begin
      qa[k] = rnd128(); qb[k] = rnd128(); qc[k] = rnd128();
      exp_q[k] = model(qa[k], qb[k], qc[k], 2'(k % 3), 1'b0, k[0], k[1], 1'b1);
    end
    for (int cy = 0; cy < 6; cy++) begin
      @(negedge clk);
      if (cy >= 2) begin
        check("R8 stream valid", 129'(out_valid), 129'(1));
        check("R8 stream data", {illegal_op, result}, exp_q[cy-2]);
      end
      if (cy < 4) begin
        drive(qa[cy], qb[cy], qc[cy], 2'(cy % 3), 1'b0, cy[0], cy[1], 1'b1);
        in_valid = 1'b1;
      end else in_valid = 1'b0;
    end

    // R9: output stall
    @(negedge clk);
    a = rnd128(); b = rnd128(); c = rnd128();
    out_ready = 1'b0;
    drive(a, b, c, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check("R9 held valid", 129'(out_valid), 129'(1));
      check("R9 in_ready low", 129'(in_ready), 129'(0));
      check("R9 held data", {illegal_op, result}, model(a, b, c, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1));
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 released", 129'(out_valid), 129'(0));
    check("R9 in_ready back", 129'(in_ready), 129'(1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R8: watchdog expired, got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule